// File: doc/BRIEF.md
# Receive Character Queue with Watermark Interrupt and Flow Control

This block buffers characters from a serial receiver until the host takes them. Each character is stored with three error flags: parity, framing and break. Data leaves in first-in, first-out order. The oldest entry is always shown at the read port, and a read strobe removes it.

A 2-bit selector sets the watermark. When the number of stored entries reaches the watermark, the block raises a data-ready interrupt, so the host can take several characters each time it is interrupted. Automatic flow control can be switched on. When it is on, the same watermark drives an active-low request-to-send line high, which tells the far end to pause. The line drops low again once the queue has drained below the watermark.

A character that arrives when the queue is full and no read happens in the same cycle is discarded, and the stored entries are left unchanged. Each such loss sets a sticky flag and increments a saturating counter. Both are cleared by a status-read strobe.

Top module: `rxq_flowctl`

## Requirements
- R1: Reset state: `empty`=1, `level`=0, `irq`=0, `rts_n`=0, `ovr_flag`=0 and `ovr_count`=0.
- R2: Entries leave in arrival order. While `empty`=0, `{rd_brk,rd_frm,rd_par,rd_char}` shows the oldest entry exactly as it was written. A cycle with `rd_en`=1 removes that entry and exposes the next one after the edge.
- R3: The queue holds DEPTH (16) entries. A write while `level`=16 and `rd_en`=0 is discarded: `level` stays 16 and the stored entries and their order are unchanged.
- R4: `trig_sel` selects the watermark: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. `irq`=1 exactly when `level` is at or above the watermark, so it clears in the same cycle that `level` falls below the watermark.
- R5: `level` reports the number of stored entries. An accepted write together with an accepted read in the same cycle leaves `level` unchanged.
- R6: With `auto_rts_en`=1, `rts_n`=1 when `level` is at or above the watermark, and `rts_n`=0 once `level` is below it. With `auto_rts_en`=0, `rts_n` is always 0.
- R7: A discarded write sets `ovr_flag` on the next edge. The flag holds until a cycle with `stat_rd`=1 clears it. If a new loss occurs in the same cycle as `stat_rd`, the set wins.
- R8: `ovr_count` increments once per discarded write, saturates at its all-ones value and is cleared by `stat_rd`.
- R9: `rd_en` while `empty`=1 has no effect: `level` stays 0 and the next written entry is the one read out.
- R10: A write arriving while `level`=16 together with `rd_en`=1 is accepted. The oldest entry leaves, `level` stays 16, and neither `ovr_flag` nor `ovr_count` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_valid | input | 1 | A received character is present this cycle |
| wr_char | input | 8 | Received character |
| wr_par | input | 1 | Parity error flag for this character |
| wr_frm | input | 1 | Framing error flag for this character |
| wr_brk | input | 1 | Break flag for this character |
| rd_en | input | 1 | Host removes the oldest entry |
| stat_rd | input | 1 | Host status read; clears the loss flag and counter |
| trig_sel | input | 2 | Watermark select (00=1, 01=4, 10=8, 11=14) |
| auto_rts_en | input | 1 | Enables automatic flow control on `rts_n` |
| rd_char | output | 8 | Character of the oldest entry |
| rd_par | output | 1 | Parity flag of the oldest entry |
| rd_frm | output | 1 | Framing flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| empty | output | 1 | No entries stored |
| level | output | 5 | Number of stored entries |
| irq | output | 1 | Data-ready interrupt |
| rts_n | output | 1 | Active-low request to send |
| ovr_flag | output | 1 | Sticky loss flag |
| ovr_count | output | OVR_W | Saturating count of lost characters |

## Verification
The bench instantiates the block with DEPTH=16, which keeps the four watermark values at 1, 4, 8 and 14. It also uses OVR_W=2, so four discarded writes are enough to reach counter saturation, well within a short full-queue test. With these values the full-plus-read case, a clear that coincides with a loss, and every watermark edge in both directions can all be reached inside one short run. Each edge is checked against a queue model kept inside the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] ch;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);

  // Watermark for a given selector, scaled from the queue depth.
  function automatic int unsigned mark_of(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   mark_of = 1;
      2'b01:   mark_of = depth / 4;
      2'b10:   mark_of = depth / 2;
      default: mark_of = depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [EW-1:0]                din,
  output logic [EW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [LW-1:0] level_nx;

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    level_nx  = level;
    if (push) wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    case ({push, pop})
      2'b10:   level_nx = level + 1'b1;
      2'b01:   level_nx = level - 1'b1;
      default: level_nx = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      level  <= level_nx;
    end
  end

  // Storage array carries no reset; contents are qualified by level.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r5_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));
endmodule

// File: rtl/rxq_mark.sv
module rxq_mark #(
  parameter int DEPTH = 16
) (
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [1:0]                 sel,
  input  logic                       auto_en,
  output logic                       irq,
  output logic                       rts_n
);
  import rxq_pkg::*;
  localparam int LW = $clog2(DEPTH+1);

  logic [LW-1:0] mark;
  logic          at_mark;

  always_comb begin
    mark    = LW'(mark_of(sel, DEPTH));
    at_mark = (level >= mark);
    irq     = at_mark;
    rts_n   = auto_en & at_mark;
  end
endmodule

// File: rtl/rxq_loss.sv
module rxq_loss #(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lost,
  input  logic             clr,
  output logic             flag,
  output logic [OVR_W-1:0] cnt
);
  localparam logic [OVR_W-1:0] CMAX = '1;

  logic             flag_nx;
  logic [OVR_W-1:0] cnt_nx;

  always_comb begin
    flag_nx = flag;
    cnt_nx  = cnt;
    if (clr) begin
      flag_nx = 1'b0;
      cnt_nx  = '0;
    end
    if (lost) begin
      flag_nx = 1'b1;
      if (!clr && cnt != CMAX) cnt_nx = cnt + 1'b1;
      if (clr)                 cnt_nx = OVR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else begin
      flag <= flag_nx;
      cnt  <= cnt_nx;
    end
  end

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r8_cnt_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !clr) |=> (cnt == CMAX));
endmodule

// File: rtl/rxq_flowctl.sv
module rxq_flowctl #(
  parameter int DEPTH = 16,
  parameter int OVR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [7:0]                 wr_char,
  input  logic                       wr_par,
  input  logic                       wr_frm,
  input  logic                       wr_brk,
  input  logic                       rd_en,
  input  logic                       stat_rd,
  input  logic [1:0]                 trig_sel,
  input  logic                       auto_rts_en,
  output logic [7:0]                 rd_char,
  output logic                       rd_par,
  output logic                       rd_frm,
  output logic                       rd_brk,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       irq,
  output logic                       rts_n,
  output logic                       ovr_flag,
  output logic [OVR_W-1:0]           ovr_count
);
  import rxq_pkg::*;
  localparam int LW = $clog2(DEPTH+1);

  logic       rst_meta, rst_q;
  logic       full, push, pop, lost;
  rxq_entry_t wr_ent, rd_ent;

  // Reset asserts at once, releases on the second edge after deassertion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    full   = (level == LW'(DEPTH));
    empty  = (level == '0);
    pop    = rd_en & ~empty;
    push   = wr_valid & (~full | pop);
    lost   = wr_valid & full & ~pop;
    wr_ent = '{brk: wr_brk, frm: wr_frm, par: wr_par, ch: wr_char};
  end

  rxq_store #(.DEPTH(DEPTH), .EW(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_q), .push(push), .pop(pop),
    .din(wr_ent), .dout(rd_ent), .level(level)
  );

  rxq_mark #(.DEPTH(DEPTH)) u_mark (
    .level(level), .sel(trig_sel), .auto_en(auto_rts_en),
    .irq(irq), .rts_n(rts_n)
  );

  rxq_loss #(.OVR_W(OVR_W)) u_loss (
    .clk(clk), .rst_n(rst_q), .lost(lost), .clr(stat_rd),
    .flag(ovr_flag), .cnt(ovr_count)
  );

  assign rd_char = rd_ent.ch;
  assign rd_par  = rd_ent.par;
  assign rd_frm  = rd_ent.frm;
  assign rd_brk  = rd_ent.brk;

  a_r3_full_kept: assert property (@(posedge clk) disable iff (!rst_q)
    (full && wr_valid && !rd_en) |=> (level == LW'(DEPTH)));
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_q)
    (empty && rd_en && !wr_valid) |=> (level == '0));
  a_r6_rts_tracks_irq: assert property (@(posedge clk) disable iff (!rst_q)
    auto_rts_en |-> (rts_n == irq));
  a_r10_full_pass: assert property (@(posedge clk) disable iff (!rst_q)
    (full && wr_valid && rd_en) |=> (level == LW'(DEPTH) && $stable(ovr_count)));
endmodule

// File: tb/sim_rxq_flowctl.sv
module sim_rxq_flowctl;
  localparam int DEPTH = 16;
  localparam int OVR_W = 2;

  logic clk, rst_n, wr_valid, wr_par, wr_frm, wr_brk, rd_en, stat_rd, auto_rts_en;
  logic [7:0] wr_char, rd_char;
  logic [1:0] trig_sel;
  logic rd_par, rd_frm, rd_brk, empty, irq, rts_n, ovr_flag;
  logic [4:0] level;
  logic [OVR_W-1:0] ovr_count;

  int n_chk = 0, n_bad = 0;
  logic [10:0] mq[$];
  int seed = 0;

  rxq_flowctl #(.DEPTH(DEPTH), .OVR_W(OVR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_char(wr_char),
    .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_en(rd_en),
    .stat_rd(stat_rd), .trig_sel(trig_sel), .auto_rts_en(auto_rts_en),
    .rd_char(rd_char), .rd_par(rd_par), .rd_frm(rd_frm), .rd_brk(rd_brk),
    .empty(empty), .level(level), .irq(irq), .rts_n(rts_n),
    .ovr_flag(ovr_flag), .ovr_count(ovr_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mark(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [10:0] next_ent();
    seed++;
    return {3'(seed % 8), 8'((seed * 37 + 11) & 8'hFF)};
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic put(input logic [10:0] e);
    wr_valid = 1'b1;
    {wr_brk, wr_frm, wr_par, wr_char} = e;
    step();
    wr_valid = 1'b0;
    if (mq.size() < DEPTH) mq.push_back(e);
  endtask

  task automatic get(input string req);
    logic [10:0] exp_e;
    exp_e = mq.pop_front();
    chk(req, int'({rd_brk, rd_frm, rd_par, rd_char}), int'(exp_e));
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) get(req);
    chk({req, " drained level"}, int'(level), 0);
  endtask

  task automatic t_reset();
    chk("R1 empty", int'(empty), 1);
    chk("R1 level", int'(level), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rts_n", int'(rts_n), 0);
    chk("R1 ovr_flag", int'(ovr_flag), 0);
    chk("R1 ovr_count", int'(ovr_count), 0);
  endtask

  task automatic t_order();
    trig_sel = 2'b00;
    put(11'h7A5);
    put(11'h05A);
    put(11'h300);
    chk("R5 level after three writes", int'(level), 3);
    chk("R2 not empty", int'(empty), 0);
    drain("R2 order and flags");
  endtask

  task automatic t_marks();
    auto_rts_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int k = 0; k < mark(2'(s)) - 1; k++) put(next_ent());
      chk("R4 irq below mark", int'(irq), 0);
      chk("R6 rts_n below mark", int'(rts_n), 0);
      put(next_ent());
      chk("R4 level at mark", int'(level), mark(2'(s)));
      chk("R4 irq at mark", int'(irq), 1);
      chk("R6 rts_n at mark", int'(rts_n), 1);
      get("R2 data at mark");
      chk("R4 irq clears below mark", int'(irq), 0);
      chk("R6 rts_n resumes below mark", int'(rts_n), 0);
      drain("R2 drain after mark");
    end
  endtask

  task automatic t_auto_off();
    auto_rts_en = 1'b0;
    trig_sel = 2'b11;
    for (int k = 0; k < 14; k++) put(next_ent());
    chk("R4 irq at 14", int'(irq), 1);
    chk("R6 rts_n held low when disabled", int'(rts_n), 0);
    drain("R2 drain auto off");
    auto_rts_en = 1'b1;
  endtask

  task automatic t_overrun();
    logic [10:0] e;
    for (int k = 0; k < DEPTH; k++) put(next_ent());
    chk("R3 level full", int'(level), DEPTH);
    chk("R7 flag before loss", int'(ovr_flag), 0);
    put(11'h7FF);
    chk("R3 level kept at full", int'(level), DEPTH);
    chk("R7 flag set", int'(ovr_flag), 1);
    chk("R8 count one", int'(ovr_count), 1);
    for (int k = 0; k < 3; k++) put(11'h7FF);
    chk("R8 count saturates", int'(ovr_count), 3);
    // R10: write with read at full
    e = next_ent();
    chk("R10 head before pass", int'({rd_brk, rd_frm, rd_par, rd_char}), int'(mq[0]));
    wr_valid = 1'b1; rd_en = 1'b1;
    {wr_brk, wr_frm, wr_par, wr_char} = e;
    step();
    wr_valid = 1'b0; rd_en = 1'b0;
    void'(mq.pop_front());
    mq.push_back(e);
    chk("R10 level stays full", int'(level), DEPTH);
    chk("R10 count unchanged", int'(ovr_count), 3);
    // R7: clear coinciding with a loss, set wins
    stat_rd = 1'b1; wr_valid = 1'b1;
    {wr_brk, wr_frm, wr_par, wr_char} = 11'h7FF;
    step();
    stat_rd = 1'b0; wr_valid = 1'b0;
    chk("R7 set wins over clear", int'(ovr_flag), 1);
    chk("R8 count restarts at one", int'(ovr_count), 1);
    step();
    chk("R7 flag holds without status read", int'(ovr_flag), 1);
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    chk("R7 flag cleared", int'(ovr_flag), 0);
    chk("R8 count cleared", int'(ovr_count), 0);
    drain("R3 contents kept after loss");
  endtask

  task automatic t_rw_and_empty();
    logic [10:0] e;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R9 level after empty read", int'(level), 0);
    chk("R9 empty after empty read", int'(empty), 1);
    put(11'h1C3);
    chk("R9 written entry at head", int'({rd_brk, rd_frm, rd_par, rd_char}), 'h1C3);
    put(next_ent());
    e = next_ent();
    wr_valid = 1'b1; rd_en = 1'b1;
    {wr_brk, wr_frm, wr_par, wr_char} = e;
    step();
    wr_valid = 1'b0; rd_en = 1'b0;
    void'(mq.pop_front());
    mq.push_back(e);
    chk("R5 level held on read plus write", int'(level), 2);
    drain("R5 order after read plus write");
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; rd_en = 1'b0; stat_rd = 1'b0;
    wr_char = '0; wr_par = 1'b0; wr_frm = 1'b0; wr_brk = 1'b0;
    trig_sel = 2'b00; auto_rts_en = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_order();
    t_marks();
    t_auto_off();
    t_overrun();
    t_rw_and_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule